// File: doc/BRIEF.md
# Comma-Aligning Deserializer with Antiphase Byte Clocks

This block turns a retimed serial bit stream, one bit per bit-clock cycle, into 10-bit parallel words. A counter marks word boundaries. When a positive-disparity comma shows up off the current boundary, the counter restarts on the comma, so the next word is cut from the ten bits that follow the comma. The block also produces two byte clocks. Each runs at half the word rate, and the two are in antiphase. Successive words are strobed by the rising edges of the two clocks in turn.

When the boundary moves, the byte clocks are only ever held longer, never cut short. If the realignment would leave the wrong clock next in line, one word slot is passed over. This places the next comma of a four-word ordered set on a rising edge of `bclk_a`. An enable input freezes the boundary. A flag travels with every word whose first seven received bits form the comma.

Top module: `comma_deser`

## Requirements
- R1: While `rst_n` is low, `word_out` is 0 and `comma_flag`, `bclk_a` and `bclk_b` are all low.
- R2: Each output word holds ten consecutive received bits, and the earliest of them sits at bit 0. With no realignment, a word is delivered on every tenth bit-clock edge after reset, starting at the tenth.
- R3: `bclk_a` and `bclk_b` are never high together. Every word delivery raises one of them and lowers the other. The first delivery after reset raises `bclk_a`. `word_out` changes only on the edge where one of the clocks rises.
- R4: A comma is a word whose bits 0 to 6 read 0,0,1,1,1,1,1, in the order they were received. Bits 7 to 9 do not matter. The value of those seven bits as a number is 7'h7C. When `sync_en` is high and a comma completes on an edge that is not a word boundary, the counter restarts there. The next word delivered then starts with the bit received right after the comma.
- R5: A level of either byte clock lasts at least ten bit-clock cycles. A realignment only lengthens the word slot in progress.
- R6: A realignment sets the clock order: the boundary ten bits after the comma must raise `bclk_b`. If `bclk_a` is not high when the comma is detected, that boundary is passed over. The word two slots after the comma is then delivered on `bclk_a`. A comma that arrives four words after the realigning one rises with `bclk_a`.
- R7: While `sync_en` is low, commas leave the word boundary where it was.
- R8: `comma_flag` is high exactly for a delivered word whose bits 0 to 6 equal 7'h7C. This holds whatever the state of `sync_en`.
- R9: A comma that completes exactly on a word boundary is delivered and flagged as an ordinary word, with no realignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; one bit is taken on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Retimed serial data |
| sync_en | input | 1 | High lets a comma realign the word boundary |
| word_out | output | 10 | Recovered parallel word; the first received bit is bit 0 |
| comma_flag | output | 1 | High while `word_out` holds a comma |
| bclk_a | output | 1 | Byte clock that rises first after reset and on commas after alignment |
| bclk_b | output | 1 | Byte clock in antiphase to `bclk_a` |

## Verification
The assertions take two things for granted about the input stream. First, commas never arrive in consecutive words. Second, a second misaligned comma never arrives before the boundary set by the first one has been reached. Without these, the block gives no guarantee about the order of the clocks. The alignment stimulus obeys both rules. It uses ordered sets of one comma followed by three data words. The data words are masked so that no window of bits can hold a run of five ones, which means the only comma in the stream is the one placed there on purpose. The exhaustive word sweep runs with `sync_en` low. Accidental commas that form across word boundaries therefore cannot move the boundary, and every one of the 1024 values is delivered where the bench expects it.

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int W = 10
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         sync_en,
  output logic [W-1:0] word_out,
  output logic         comma_flag,
  output logic         bclk_a,
  output logic         bclk_b
);
  localparam int CW = $clog2(W);
  localparam int PW = 7;
  localparam logic [PW-1:0] COMMA = 7'b1111100;
  localparam int LW = CW + 2;

  logic [W-1:0]  sr;
  logic [W-1:0]  nxt;
  logic [CW-1:0] cnt;
  logic          skip;
  logic          last;
  logic          hit;
  logic          realign;

  assign nxt     = {ser_in, sr[W-1:1]};
  assign last    = (cnt == CW'(W - 1));
  assign hit     = (nxt[PW-1:0] == COMMA);
  assign realign = sync_en && hit && !last;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      cnt        <= '0;
      skip       <= 1'b0;
      word_out   <= '0;
      comma_flag <= 1'b0;
      bclk_a     <= 1'b0;
      bclk_b     <= 1'b0;
    end else begin
      sr <= nxt;
      if (last) begin
        cnt  <= '0;
        skip <= 1'b0;
        if (!skip) begin
          word_out   <= nxt;
          comma_flag <= hit;
          bclk_a     <= ~bclk_a;
          bclk_b     <= bclk_a;
        end
      end else if (realign) begin
        cnt  <= '0;
        skip <= ~bclk_a;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic          a_q;
  logic [LW-1:0] lvl;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      lvl <= '0;
    end else begin
      a_q <= bclk_a;
      if (bclk_a != a_q)
        lvl <= LW'(1);
      else if (lvl != '1)
        lvl <= lvl + 1'b1;
    end
  end

  assert_min_level_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (bclk_a != a_q) |-> (lvl >= LW'(W)));

  assert_never_both_high_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !(bclk_a && bclk_b));

  assert_word_moves_on_rise_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !$stable(word_out) |-> ($rose(bclk_a) || $rose(bclk_b)));

  assert_flag_means_comma_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    comma_flag |-> (word_out[PW-1:0] == COMMA));

  assert_boundary_frozen_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!sync_en && !last) |=> (cnt == CW'($past(cnt) + 1'b1)));

  assert_realign_restart_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    realign |=> ((cnt == '0) && $stable(word_out) && $stable(bclk_a)));
endmodule

// File: tb/test_comma_deser.sv
module test_comma_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       sync_en = 1'b0;
  logic [9:0] word_out;
  logic       comma_flag, bclk_a, bclk_b;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit prev_a = 1'b0;
  int run = 0;
  bit sbits [0:255];

  localparam logic [9:0] CWORD = 10'h17C;

  comma_deser #(.W(10)) i_comma_deser (
    .bit_clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_en(sync_en),
    .word_out(word_out), .comma_flag(comma_flag), .bclk_a(bclk_a), .bclk_b(bclk_b)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] dat(input int i);
    return 10'(i * 147 + 29) & 10'h1B6;
  endfunction

  function automatic logic [9:0] win(input int n);
    logic [9:0] v;
    for (int j = 0; j < 10; j++) v[j] = sbits[n - 9 + j];
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    ser_in = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk(word_out == 0 && !comma_flag && !bclk_a && !bclk_b, "R1", "reset state",
        {word_out, comma_flag, bclk_a, bclk_b}, 0);
    rst_n = 1'b1;
    prev_a = 1'b0;
    run = 0;
  endtask

  task automatic send_bit(input bit b);
    ser_in = b;
    @(posedge clk);
    #5;
    if (bclk_a != prev_a) begin
      chk(run + 1 >= 10, "R5", "bclk_a level length", run + 1, 10);
      run = 0;
      prev_a = bclk_a;
    end else begin
      run++;
    end
  endtask

  task automatic sweep_words();
    do_reset();
    sync_en = 1'b0;
    for (int v = 0; v < 1024; v++) begin
      for (int j = 0; j < 10; j++) send_bit(v[j]);
      chk(word_out == 10'(v), "R2", "word value", word_out, v);
      chk(comma_flag == ((v & 'h7F) == 'h7C), "R8", "comma flag", comma_flag, (v & 'h7F) == 'h7C);
      chk(bclk_a == v[0] ? 1'b0 : 1'b1, "R3", "clock order", {bclk_a, bclk_b}, v[0] ? 1 : 2);
      chk(bclk_b == v[0], "R3", "bclk_b antiphase", bclk_b, v[0]);
    end
  endtask

  task automatic run_align(input int p, input bit en);
    int len, e, m, nb;
    bit aligned;
    logic [9:0] val;
    do_reset();
    sync_en = en;
    len = p + 200;
    for (int i = 1; i <= p; i++) sbits[i] = 1'b0;
    for (int s = 0; s < 5; s++)
      for (int q = 0; q < 4; q++) begin
        val = (q == 0) ? CWORD : dat(s * 4 + q);
        for (int j = 0; j < 10; j++) sbits[p + s * 40 + q * 10 + j + 1] = val[j];
      end
    e = p + 10;
    aligned = (e % 10 == 0);
    m = (e - 1) / 10;
    nb = ((e + 40) / 10) * 10;
    for (int n = 1; n <= len; n++) begin
      send_bit(sbits[n]);
      if (en && aligned && (n == e || n == e + 40)) begin
        chk(word_out == CWORD, "R9", "aligned comma word", word_out, CWORD);
        chk(comma_flag, "R8", "aligned comma flag", comma_flag, 1);
        chk(bclk_a == ((n / 10) % 2 == 1), "R9", "aligned comma clock", bclk_a, (n / 10) % 2);
      end
      if (en && !aligned) begin
        if (m % 2 == 1 && n == e + 10) begin
          chk(word_out == dat(1), "R4", "word after comma", word_out, dat(1));
          chk(!bclk_a && bclk_b, "R6", "bclk_b after realign", {bclk_a, bclk_b}, 1);
        end
        if (m % 2 == 0 && n == e + 10) begin
          chk(word_out == win(10 * m), "R5", "slot stretched, word held", word_out, win(10 * m));
          chk(bclk_b && !bclk_a, "R5", "bclk_b held high", {bclk_a, bclk_b}, 1);
        end
        if (m % 2 == 0 && n == e + 20) begin
          chk(word_out == dat(2), "R4", "second word after comma", word_out, dat(2));
          chk(bclk_a && !bclk_b, "R6", "bclk_a after skip", {bclk_a, bclk_b}, 2);
        end
        if (n == e + 40) begin
          chk(word_out == CWORD, "R6", "second comma word", word_out, CWORD);
          chk(comma_flag, "R8", "second comma flag", comma_flag, 1);
          chk(bclk_a && !bclk_b, "R6", "second comma on bclk_a", {bclk_a, bclk_b}, 2);
        end
      end
      if (!en && n == nb) begin
        chk(word_out == win(nb), "R7", "boundary kept", word_out, win(nb));
        chk(!comma_flag, "R7", "no flag off boundary", comma_flag, 0);
        chk(bclk_a == ((nb / 10) % 2 == 1), "R7", "clock order kept", bclk_a, (nb / 10) % 2);
      end
    end
  endtask

  initial begin
    sweep_words();
    for (int p = 0; p < 30; p++) run_align(p, 1'b1);
    run_align(3, 1'b0);
    run_align(17, 1'b0);
    run_align(26, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule